// File: doc/BRIEF.md
# Packet Credit Release Counter

This block tracks how many packets are outstanding for each notification ring and for each load-balancing bucket. A dispatch path raises the counts: each dispatched packet adds one to its ring and one to its bucket. Software hands credits back with memory-mapped stores. The store address selects a ring, a bucket and which of the two to release. The low half-word of the store data says how many packets are returned.

A single store can lower a ring counter, a bucket counter, or both in the same cycle, because each target has its own enable bit in the address. Counters never wrap. A release larger than the current count stops at zero and sets a sticky underflow flag for that array. An increment stops at the counter's maximum value.

Two combinational read ports let the surrounding logic observe any ring count and any bucket count. Any address bits not listed below are not decoded, and that includes the service-domain index.

Top module: `credit_release_ctr`

## Requirements
- R1: A store is acted on only when address bits [28:26] hold the region code 4. Any other region code leaves every counter and both flags unchanged.
- R2: The ring index is taken from address bits [10:3] and the bucket index from address bits [23:11].
- R3: Address bit 24 enables the ring release and address bit 25 enables the bucket release. Either bit can be set alone, or both can be set together.
- R4: Data bits [15:0] give the release amount, which is subtracted from each enabled counter. Data bits above 15 have no effect.
- R5: A store in the right region with neither enable bit set changes nothing.
- R6: A release that exceeds the counter's value leaves the counter at zero and sets the underflow flag of that array (`ring_uflow` or `bkt_uflow`). The flag then stays set until reset.
- R7: When `inc_vld` is high, the ring `inc_ring` and the bucket `inc_bkt` each gain one per cycle, and a counter stops at its maximum of 2^CNT_W-1.
- R8: If an increment and a release reach the same counter in one cycle, the counter takes the net result of the two.
- R9: A bucket index of N_BKT or more drops the bucket part of the store, and no bucket is aliased. The ring part of the same store still applies.
- R10: After reset, every counter reads zero and both flags are low.
- R11: A store or increment accepted at a rising edge shows on the read ports right after that edge. The read ports follow their index inputs with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store strobe |
| wr_addr | input | ADDR_W (64) | Store address |
| wr_data | input | DATA_W (64) | Store data; bits [15:0] hold the release amount |
| inc_vld | input | 1 | Dispatch increment strobe |
| inc_ring | input | log2(N_RING) (8) | Ring to increment |
| inc_bkt | input | log2(N_BKT) (6) | Bucket to increment |
| rd_ring_idx | input | log2(N_RING) (8) | Ring read index |
| rd_ring_cnt | output | CNT_W (16) | Count of the indexed ring |
| rd_bkt_idx | input | log2(N_BKT) (6) | Bucket read index |
| rd_bkt_cnt | output | CNT_W (16) | Count of the indexed bucket |
| ring_uflow | output | 1 | Sticky ring underflow flag |
| bkt_uflow | output | 1 | Sticky bucket underflow flag |

## Verification
Every store and increment is written into the counters at the rising edge where its strobe is high. Because the read ports are combinational, the new values can be seen straight after that edge, and the underflow flags can too. The bench therefore drives each strobe for exactly one cycle, starting at a falling edge. It steers the read indexes at the following falling edge and compares a short delay later, so the compare never lands on a clock edge. The long saturation scenario is handled the same way: the strobe stays high for a known number of rising edges, and the bench samples after the last of them.

// File: rtl/crc_pkg.sv
package crc_pkg;
   localparam int unsigned REGION_LSB  = 26;
   localparam int unsigned REGION_W    = 3;
   localparam logic [2:0]  REGION_REL  = 3'd4;
   localparam int unsigned RING_LSB    = 3;
   localparam int unsigned RING_FW     = 8;
   localparam int unsigned BKT_LSB     = 11;
   localparam int unsigned BKT_FW      = 13;
   localparam int unsigned RING_EN_BIT = 24;
   localparam int unsigned BKT_EN_BIT  = 25;
   localparam int unsigned AMT_W       = 16;

   typedef struct packed {
      logic               ring_go;
      logic               bkt_go;
      logic [RING_FW-1:0] ring;
      logic [BKT_FW-1:0]  bkt;
      logic [AMT_W-1:0]   amt;
   } rel_cmd_t;
endpackage

// File: rtl/crc_decode.sv
module crc_decode
   import crc_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned N_RING = 256,
   parameter int unsigned N_BKT  = 64
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output rel_cmd_t          cmd
);
   logic hit;

   always_comb begin
      hit         = wr_en && (wr_addr[REGION_LSB +: REGION_W] == REGION_REL);
      cmd.ring    = wr_addr[RING_LSB +: RING_FW];
      cmd.bkt     = wr_addr[BKT_LSB +: BKT_FW];
      cmd.amt     = wr_data[AMT_W-1:0];
      cmd.ring_go = hit && wr_addr[RING_EN_BIT] && (32'(cmd.ring) < N_RING);
      cmd.bkt_go  = hit && wr_addr[BKT_EN_BIT] && (32'(cmd.bkt) < N_BKT);
   end
endmodule

// File: rtl/crc_bank.sv
module crc_bank #(
   parameter int unsigned N     = 64,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned AMT_W = 16,
   localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1,
   localparam int unsigned WW   = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_en,
   input  logic [IW-1:0]    inc_idx,
   input  logic             dec_en,
   input  logic [IW-1:0]    dec_idx,
   input  logic [AMT_W-1:0] dec_amt,
   input  logic [IW-1:0]    rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   output logic             uflow
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_vec [N];
   logic [N-1:0]     uf_vec;

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic             inc_hit, dec_hit, uf;
      logic [WW-1:0]    up, need, diff;
      logic [CNT_W-1:0] nxt, q;

      always_comb begin
         inc_hit = inc_en && (inc_idx == IW'(i));
         dec_hit = dec_en && (dec_idx == IW'(i));
         up      = WW'(q) + WW'(inc_hit);
         need    = dec_hit ? WW'(dec_amt) : '0;
         uf      = need > up;
         diff    = uf ? '0 : (up - need);
         nxt     = (diff > WW'(CNT_MAX)) ? CNT_MAX : diff[CNT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end

      assign cnt_vec[i] = q;
      assign uf_vec[i]  = uf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        uflow <= 1'b0;
      else if (|uf_vec)  uflow <= 1'b1;
   end

   assign rd_cnt = (32'(rd_idx) < N) ? cnt_vec[rd_idx] : '0;
endmodule

// File: rtl/credit_release_ctr.sv
module credit_release_ctr
   import crc_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned N_RING = 256,
   parameter int unsigned N_BKT  = 64,
   parameter int unsigned CNT_W  = 16,
   localparam int unsigned RIW   = $clog2(N_RING),
   localparam int unsigned BIW   = $clog2(N_BKT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              inc_vld,
   input  logic [RIW-1:0]    inc_ring,
   input  logic [BIW-1:0]    inc_bkt,
   input  logic [RIW-1:0]    rd_ring_idx,
   output logic [CNT_W-1:0]  rd_ring_cnt,
   input  logic [BIW-1:0]    rd_bkt_idx,
   output logic [CNT_W-1:0]  rd_bkt_cnt,
   output logic              ring_uflow,
   output logic              bkt_uflow
);
   if (N_RING < 2 || N_RING > (1 << RING_FW)) begin : g_bad_ring
      $error("N_RING must lie in 2..256");
   end
   if (N_BKT < 2 || N_BKT > (1 << BKT_FW)) begin : g_bad_bkt
      $error("N_BKT must lie in 2..8192");
   end
   if (ADDR_W < BKT_EN_BIT + 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the region field");
   end
   if (DATA_W < AMT_W || CNT_W < 1) begin : g_bad_data
      $error("DATA_W or CNT_W too narrow");
   end

   rel_cmd_t cmd;

   crc_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RING(N_RING), .N_BKT(N_BKT)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd)
   );

   crc_bank #(.N(N_RING), .CNT_W(CNT_W), .AMT_W(AMT_W)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .inc_en(inc_vld), .inc_idx(inc_ring),
      .dec_en(cmd.ring_go), .dec_idx(cmd.ring[RIW-1:0]), .dec_amt(cmd.amt),
      .rd_idx(rd_ring_idx), .rd_cnt(rd_ring_cnt), .uflow(ring_uflow)
   );

   crc_bank #(.N(N_BKT), .CNT_W(CNT_W), .AMT_W(AMT_W)) u_bkt (
      .clk(clk), .rst_n(rst_n),
      .inc_en(inc_vld), .inc_idx(inc_bkt),
      .dec_en(cmd.bkt_go), .dec_idx(cmd.bkt[BIW-1:0]), .dec_amt(cmd.amt),
      .rd_idx(rd_bkt_idx), .rd_cnt(rd_bkt_cnt), .uflow(bkt_uflow)
   );
endmodule

// File: rtl/credit_release_chk.sv
module credit_release_chk
   import crc_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned RIW    = 8,
   parameter int unsigned BIW    = 6,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              inc_vld,
   input logic [RIW-1:0]    rd_ring_idx,
   input logic [CNT_W-1:0]  rd_ring_cnt,
   input logic [BIW-1:0]    rd_bkt_idx,
   input logic [CNT_W-1:0]  rd_bkt_cnt,
   input logic              ring_uflow,
   input logic              bkt_uflow
);
   logic bad_region, no_enable;
   assign bad_region = wr_en && (wr_addr[REGION_LSB +: REGION_W] != REGION_REL);
   assign no_enable  = wr_en && !wr_addr[RING_EN_BIT] && !wr_addr[BKT_EN_BIT];

   // R6
   ring_uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_uflow |=> ring_uflow);
   // R6
   bkt_uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bkt_uflow |=> bkt_uflow);
   // R6
   ring_uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ring_uflow) |-> $past(wr_en));
   // R1
   bad_region_ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_region && !inc_vld) ##1 $stable(rd_ring_idx) |-> $stable(rd_ring_cnt));
   // R1
   bad_region_bkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_region && !inc_vld) ##1 $stable(rd_bkt_idx) |-> $stable(rd_bkt_cnt));
   // R5
   no_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_enable && !inc_vld) ##1 $stable(rd_ring_idx) |-> $stable(rd_ring_cnt));
   // R11
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !inc_vld) ##1 $stable(rd_bkt_idx) |-> $stable(rd_bkt_cnt));
   // R4
   ring_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rd_ring_idx) && (rd_ring_cnt < $past(rd_ring_cnt))) |-> $past(wr_en));
endmodule

bind credit_release_ctr credit_release_chk #(
   .ADDR_W(ADDR_W), .RIW(RIW), .BIW(BIW), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .inc_vld(inc_vld),
   .rd_ring_idx(rd_ring_idx), .rd_ring_cnt(rd_ring_cnt),
   .rd_bkt_idx(rd_bkt_idx), .rd_bkt_cnt(rd_bkt_cnt),
   .ring_uflow(ring_uflow), .bkt_uflow(bkt_uflow)
);

// File: tb/credit_release_ctr_bench.sv
module credit_release_ctr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic        inc_vld = 1'b0;
   logic [7:0]  inc_ring = '0;
   logic [5:0]  inc_bkt = '0;
   logic [7:0]  rd_ring_idx = '0;
   logic [15:0] rd_ring_cnt;
   logic [5:0]  rd_bkt_idx = '0;
   logic [15:0] rd_bkt_cnt;
   logic        ring_uflow, bkt_uflow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int exp_r [256];
   int exp_b [64];
   bit exp_ruf = 0;
   bit exp_buf = 0;

   always #2 clk = ~clk;

   credit_release_ctr u_credit_release_ctr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inc_vld(inc_vld), .inc_ring(inc_ring), .inc_bkt(inc_bkt),
      .rd_ring_idx(rd_ring_idx), .rd_ring_cnt(rd_ring_cnt),
      .rd_bkt_idx(rd_bkt_idx), .rd_bkt_cnt(rd_bkt_cnt),
      .ring_uflow(ring_uflow), .bkt_uflow(bkt_uflow)
   );

   function automatic logic [63:0] mk_addr(input int region, input int ring, input int bkt,
                                           input bit ren, input bit ben);
      logic [63:0] a = '0;
      a[28:26] = region[2:0];
      a[10:3]  = ring[7:0];
      a[23:11] = bkt[12:0];
      a[24]    = ren;
      a[25]    = ben;
      a[40:36] = 5'h15;
      a[2:0]   = 3'b101;
      return a;
   endfunction

   task automatic chk_ring(input int idx, input string req);
      rd_ring_idx = idx[7:0];
      #1;
      n_chk++;
      if (rd_ring_cnt !== 16'(exp_r[idx])) begin
         n_bad++;
         $display("FAIL %s ring %0d actual=%0d expected=%0d", req, idx, rd_ring_cnt, exp_r[idx]);
      end
   endtask

   task automatic chk_bkt(input int idx, input string req);
      rd_bkt_idx = idx[5:0];
      #1;
      n_chk++;
      if (rd_bkt_cnt !== 16'(exp_b[idx])) begin
         n_bad++;
         $display("FAIL %s bucket %0d actual=%0d expected=%0d", req, idx, rd_bkt_cnt, exp_b[idx]);
      end
   endtask

   task automatic chk_flags(input string req);
      n_chk++;
      if (ring_uflow !== exp_ruf || bkt_uflow !== exp_buf) begin
         n_bad++;
         $display("FAIL %s flags actual=%b%b expected=%b%b", req,
                  ring_uflow, bkt_uflow, exp_ruf, exp_buf);
      end
   endtask

   function automatic int rel(input int cur, input int amt, inout bit flag);
      if (amt > cur) begin flag = 1; return 0; end
      return cur - amt;
   endfunction

   task automatic do_store(input int region, input int ring, input int bkt,
                           input bit ren, input bit ben, input int amt);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = mk_addr(region, ring, bkt, ren, ben);
      wr_data = {48'hBEEF_0000_FFFF, amt[15:0]};
      @(negedge clk);
      wr_en   = 1'b0;
      if (region == 4) begin
         if (ren) exp_r[ring] = rel(exp_r[ring], amt, exp_ruf);
         if (ben && bkt < 64) exp_b[bkt] = rel(exp_b[bkt], amt, exp_buf);
      end
   endtask

   task automatic do_inc(input int ring, input int bkt, input int n);
      @(negedge clk);
      inc_vld  = 1'b1;
      inc_ring = ring[7:0];
      inc_bkt  = bkt[5:0];
      repeat (n) @(negedge clk);
      inc_vld  = 1'b0;
      exp_r[ring] = (exp_r[ring] + n > 65535) ? 65535 : exp_r[ring] + n;
      exp_b[bkt]  = (exp_b[bkt] + n > 65535) ? 65535 : exp_b[bkt] + n;
   endtask

   task automatic t_reset();
      chk_ring(0, "R10");
      chk_ring(255, "R10");
      chk_bkt(63, "R10");
      chk_flags("R10");
   endtask

   task automatic t_ring_only();
      do_inc(5, 2, 10);
      chk_ring(5, "R7");
      chk_bkt(2, "R7");
      do_store(4, 5, 2, 1, 0, 3);
      chk_ring(5, "R3 ring only, R2 ring field");
      chk_bkt(2, "R3 bucket untouched");
   endtask

   task automatic t_bkt_only();
      do_store(4, 5, 2, 0, 1, 4);
      chk_bkt(2, "R3 bucket only, R2 bucket field");
      chk_ring(5, "R3 ring untouched");
   endtask

   task automatic t_both();
      do_inc(77, 40, 20);
      do_store(4, 77, 40, 1, 1, 16'd7);
      chk_ring(77, "R3 both, R4 amount");
      chk_bkt(40, "R3 both, R4 amount");
   endtask

   task automatic t_bad_region();
      do_store(6, 77, 40, 1, 1, 2);
      chk_ring(77, "R1 region 6");
      chk_bkt(40, "R1 region 6");
      do_store(0, 5, 2, 1, 1, 1);
      chk_ring(5, "R1 region 0");
   endtask

   task automatic t_no_enable();
      do_store(4, 77, 40, 0, 0, 5);
      chk_ring(77, "R5");
      chk_bkt(40, "R5");
      chk_flags("R5");
   endtask

   task automatic t_underflow();
      do_inc(3, 9, 2);
      do_store(4, 3, 9, 1, 0, 5);
      chk_ring(3, "R6 ring saturates at zero");
      chk_flags("R6 ring flag only");
      do_store(4, 3, 9, 0, 1, 9);
      chk_bkt(9, "R6 bucket saturates at zero");
      chk_flags("R6 both flags");
      do_inc(3, 9, 1);
      chk_flags("R6 flags sticky");
   endtask

   task automatic t_net();
      do_inc(12, 13, 4);
      @(negedge clk);
      inc_vld  = 1'b1; inc_ring = 8'd12; inc_bkt = 6'd13;
      wr_en    = 1'b1;
      wr_addr  = mk_addr(4, 12, 13, 1, 1);
      wr_data  = 64'd3;
      @(negedge clk);
      inc_vld  = 1'b0; wr_en = 1'b0;
      exp_r[12] = 2; exp_b[13] = 2;
      chk_ring(12, "R8 net change");
      chk_bkt(13, "R8 net change");
   endtask

   task automatic t_bkt_range();
      do_inc(11, 36, 5);
      do_store(4, 11, 100, 1, 1, 2);
      chk_bkt(36, "R9 no alias");
      chk_ring(11, "R9 ring part applies");
   endtask

   task automatic t_sat();
      do_inc(200, 50, 65540);
      chk_ring(200, "R7 saturate at max");
      chk_bkt(50, "R7 saturate at max");
      do_store(4, 200, 50, 1, 1, 1);
      chk_ring(200, "R11 after release");
      chk_bkt(50, "R11 after release");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) exp_r[i] = 0;
      for (int i = 0; i < 64; i++) exp_b[i] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ring_only();
      t_bkt_only();
      t_both();
      t_bad_region();
      t_no_enable();
      t_underflow();
      t_net();
      t_bkt_range();
      t_sat();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule